// File: doc/BRIEF.md
# Dual-Resolution System Timebase Counter

This block keeps system time as one free-running binary counter that moves forward by one on each cycle carrying a 250 ns tick strobe. The same register is read in two ways. The low 32 bits give time in 250 ns units. The bits from 2 upward give time in 1 µs units. No divider or second counter is involved.

A clock-enable control must be set before the counter moves. A halt-mode control decides whether the counter pauses while the CPU reports that it is halted. When the counter wraps, the block raises a one-cycle overflow pulse. A select mask picks counter bits and ORs them onto a registered event line, which downstream logic can use as a periodic trigger.

All outputs come straight from registers. The counter width and the mask width are parameters. With the default counter width of 34 bits, each view is 32 bits wide.

Top module: `sys_timebase`

## Requirements
- R1: While reset is held and in the first cycle after it, both time views, `running_o`, `ovf_pulse_o` and `bit_evt_o` read 0.
- R2: The counter advances by exactly one on each clock edge where `tick_i` is 1, `clk_en_i` is 1 and no halt freeze applies. On every other edge it holds. `time_fine_o` shows counter bits [CNT_W-3:0].
- R3: `time_coarse_o` shows counter bits [CNT_W-1:2], so it steps once for every four steps of the fine view.
- R4: While `clk_en_i` is 0, the counter holds its value even when `tick_i` pulses.
- R5: While `halt_mode_i` is 0, the value of `cpu_halt_i` has no effect on counting.
- R6: While `halt_mode_i` is 1 and `cpu_halt_i` is 1, the counter holds. It resumes on the first tick after `cpu_halt_i` returns to 0, keeping the value it held.
- R7: When the counter steps from all ones to zero, `ovf_pulse_o` is 1 for exactly the one cycle in which the views first read zero. At all other times it is 0.
- R8: Bit k of `bit_sel_i` selects counter bit k+2. `bit_evt_o` is the OR of all selected counter bits and is registered: it reflects the counter and mask of the previous cycle. An all-zero mask gives 0.
- R9: `running_o` is 1 in the cycle after an edge where `clk_en_i` is 1 and no halt freeze applies. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 250 ns tick strobe, one clock wide |
| cpu_halt_i | input | 1 | CPU reports that it is halted |
| halt_mode_i | input | 1 | 1: freeze while halted; 0: ignore halt |
| clk_en_i | input | 1 | Counting enable |
| bit_sel_i | input | SEL_W (16) | Mask selecting counter bits 2 and up for forwarding |
| time_fine_o | output | CNT_W-2 (32) | Time in 250 ns units |
| time_coarse_o | output | CNT_W-2 (32) | Time in 1 µs units |
| running_o | output | 1 | Timer enabled and not frozen |
| ovf_pulse_o | output | 1 | One-cycle pulse on counter wrap |
| bit_evt_o | output | 1 | Registered OR of the selected counter bits |

## Verification
The counter is driven with back-to-back ticks, with ticks that have idle cycles between them, and with ticks that arrive while the block is disabled or frozen. Comparing the results separates a counter that steps on the tick alone from one that also honours the enable and the halt gating. The halt input is applied in both halt modes, which shows whether the mode bit is used or ignored. Single-bit, multi-bit and empty masks are applied to known counter values, which tells an OR from an AND or a mis-offset bit. A narrow second instance is run through a full wrap, so that the overflow pulse and its alignment with the zero reading can be observed.

// File: rtl/sys_timebase.sv
module sys_timebase #(
  parameter int CNT_W = 34,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cpu_halt_i,
  input  logic             halt_mode_i,
  input  logic             clk_en_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  output logic [CNT_W-3:0] time_fine_o,
  output logic [CNT_W-3:0] time_coarse_o,
  output logic             running_o,
  output logic             ovf_pulse_o,
  output logic             bit_evt_o
);
  localparam int SEL_LSB = 2;
  localparam int VIEW_W  = CNT_W - 2;

  logic [CNT_W-1:0] cnt;
  logic             freeze;
  logic             advance;
  logic [SEL_W-1:0] tapped;

  assign freeze  = halt_mode_i & cpu_halt_i;
  assign advance = tick_i & clk_en_i & ~freeze;
  assign tapped  = cnt[SEL_LSB +: SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      ovf_pulse_o <= 1'b0;
      bit_evt_o   <= 1'b0;
      running_o   <= 1'b0;
    end else begin
      if (advance) cnt <= cnt + CNT_W'(1);
      ovf_pulse_o <= advance & (&cnt);
      bit_evt_o   <= |(tapped & bit_sel_i);
      running_o   <= clk_en_i & ~freeze;
    end
  end

  assign time_fine_o   = cnt[VIEW_W-1:0];
  assign time_coarse_o = cnt[CNT_W-1:SEL_LSB];

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && clk_en_i && !(halt_mode_i && cpu_halt_i))
      |=> time_fine_o == VIEW_W'($past(time_fine_o) + VIEW_W'(1))); // R2

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i |=> $stable(time_fine_o) && $stable(time_coarse_o)); // R4

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_mode_i && cpu_halt_i) |=> $stable(time_coarse_o) && $stable(time_fine_o)); // R6

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse_o |=> !ovf_pulse_o); // R7

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse_o |-> (time_fine_o == '0 && time_coarse_o == '0)); // R7

  AST_RUN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i |=> !running_o); // R9

endmodule

// File: tb/tb_sys_timebase.sv
module tb_sys_timebase;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, cpu_halt_i = 1'b0, halt_mode_i = 1'b0, clk_en_i = 1'b0;
  logic [15:0] sel_big = '0;
  logic [3:0]  sel_small = '0;
  logic [31:0] fine, coarse;
  logic [5:0]  s_fine, s_coarse;
  logic run, ovf, evt, s_run, s_ovf, s_evt;

  always #10 clk = ~clk;

  sys_timebase dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cpu_halt_i(cpu_halt_i),
    .halt_mode_i(halt_mode_i), .clk_en_i(clk_en_i), .bit_sel_i(sel_big),
    .time_fine_o(fine), .time_coarse_o(coarse), .running_o(run),
    .ovf_pulse_o(ovf), .bit_evt_o(evt));

  sys_timebase #(.CNT_W(8), .SEL_W(4)) dut_s (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cpu_halt_i(cpu_halt_i),
    .halt_mode_i(halt_mode_i), .clk_en_i(clk_en_i), .bit_sel_i(sel_small),
    .time_fine_o(s_fine), .time_coarse_o(s_coarse), .running_o(s_run),
    .ovf_pulse_o(s_ovf), .bit_evt_o(s_evt));

  typedef struct { string req; int sig; logic [63:0] exp; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [33:0] m = '0;
  string names[9] = '{"fine", "coarse", "running", "ovf", "evt",
                      "s_fine", "s_coarse", "s_ovf", "s_evt"};

  function automatic logic [63:0] actual(int s);
    case (s)
      0: return 64'(fine);
      1: return 64'(coarse);
      2: return 64'(run);
      3: return 64'(ovf);
      4: return 64'(evt);
      5: return 64'(s_fine);
      6: return 64'(s_coarse);
      7: return 64'(s_ovf);
      default: return 64'(s_evt);
    endcase
  endfunction

  task automatic push(string r, int s, logic [63:0] e);
    item_t it;
    it.req = r; it.sig = s; it.exp = e;
    q.push_back(it);
  endtask

  task automatic push_views(string r);
    push(r, 0, 64'(m[31:0]));
    push(r, 1, 64'(m[33:2]));
    push(r, 5, 64'(m[5:0]));
    push(r, 6, 64'(m[7:2]));
  endtask

  task automatic run_ticks(int n, logic t);
    repeat (n) begin
      tick_i = t;
      @(negedge clk);
      if (t && clk_en_i && !(halt_mode_i && cpu_halt_i)) m = m + 34'd1;
    end
    tick_i = 1'b0;
  endtask

  always begin
    @(negedge clk);
    #5;
    while (q.size() > 0) begin
      item_t it;
      logic [63:0] a;
      it = q.pop_front();
      a = actual(it.sig);
      n_run++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s actual=%0h expected=%0h", it.req, names[it.sig], a, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push("R1", 0, 0); push("R1", 1, 0); push("R1", 2, 0);
    push("R1", 3, 0); push("R1", 4, 0);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1", 0, 0); push("R1", 2, 0); push("R1", 7, 0); push("R1", 8, 0);

    run_ticks(5, 1'b1);
    push_views("R4"); push("R9", 2, 0);

    clk_en_i = 1'b1;
    run_ticks(1, 1'b1);
    push_views("R2"); push("R9", 2, 1);
    run_ticks(12, 1'b1);
    push_views("R3"); push("R3", 1, 3);

    // m = 13 (binary 1101): bit2=1, bit3=1, bit4=0, bit5=0
    sel_big = 16'h0001; sel_small = 4'h0;
    run_ticks(1, 1'b0);
    push("R8", 4, 1); push("R8", 8, 0);
    sel_big = 16'h0004; sel_small = 4'h8;
    run_ticks(1, 1'b0);
    push("R8", 4, 0); push("R8", 8, 0);
    sel_big = 16'h0006; sel_small = 4'h6;
    run_ticks(1, 1'b0);
    push("R8", 4, 1); push("R8", 8, 1);
    sel_big = 16'h0000;
    run_ticks(1, 1'b0);
    push("R8", 4, 0);

    cpu_halt_i = 1'b1;
    run_ticks(3, 1'b1);
    push_views("R5"); push("R5", 0, 16); push("R5", 2, 1);

    halt_mode_i = 1'b1;
    run_ticks(4, 1'b1);
    push_views("R6"); push("R6", 0, 16); push("R9", 2, 0);
    cpu_halt_i = 1'b0;
    run_ticks(2, 1'b1);
    push_views("R6"); push("R6", 0, 18); push("R9", 2, 1);

    for (int i = 0; i < 6; i++) run_ticks(1, (i % 2) == 0);
    push_views("R2"); push("R2", 0, 21);

    sel_small = 4'h8;
    run_ticks(234, 1'b1);
    push_views("R7"); push("R7", 7, 0); push("R7", 3, 0);
    run_ticks(1, 1'b0);
    push("R8", 8, 1);
    run_ticks(1, 1'b1);
    push_views("R7"); push("R7", 7, 1); push("R7", 5, 0); push("R3", 1, 64);
    run_ticks(1, 1'b0);
    push("R7", 7, 0); push("R7", 3, 0); push("R8", 8, 0);

    clk_en_i = 1'b0;
    run_ticks(3, 1'b1);
    push_views("R4"); push("R4", 0, 256); push("R9", 2, 0);

    repeat (2) @(negedge clk);
    #8;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule